// File: doc/BRIEF.md
# Timer Interrupt Pacing Controller

This block sits between a periodic timer and an interrupt controller. Each timer expiry arrives as a one-cycle tick strobe. The block turns these ticks into interrupt request pulses, but it never lets more than one interrupt be outstanding. Ticks that arrive while an interrupt is still unacknowledged are not dropped. They are held in a pending counter, and each one is delivered later, one at a time, after the interrupt before it has been acknowledged.

The block keeps two pieces of state: an 8-bit pending count and a ready flag. The ready flag means the previous interrupt has been acknowledged. An interrupt is issued when the count is nonzero and the flag is set, and issuing it clears the flag. An acknowledge removes one pending tick and sets the flag again. Two events start the block over from a clean state: unmasking the interrupt line, and reloading the timer. The pending count can be watched on an observation port.

Top module: `timpace_ctrl`

## Requirements
- R1: After reset, `pend_o` is 0 and `irq_o` is 0. The ready flag is set, so the first tick after reset is delivered without waiting for an acknowledge.
- R2: A tick with no acknowledge, unmask or reload in the same cycle increments `pend_o` by one. At 255 the count saturates and stays at 255.
- R3: A request is issued only in a cycle where the registered pending count is nonzero and the ready flag is set. Issuing a request clears the flag. After that, no further request is issued until an acknowledge, unmask or reload sets the flag again.
- R4: Each request is a pulse on `irq_o` that lasts exactly one cycle. The pulse appears in the cycle after the clock edge at which the issue decision is taken.
- R5: An acknowledge with no tick, unmask or reload in the same cycle decrements a nonzero `pend_o` by one and sets the ready flag.
- R6: A tick and an acknowledge in the same cycle leave `pend_o` unchanged and set the ready flag.
- R7: An unmask event clears `pend_o` to 0 and sets the ready flag. It takes priority over a tick or acknowledge in the same cycle.
- R8: A reload event clears `pend_o` to 0 and sets the ready flag.
- R9: An acknowledge when `pend_o` is 0 leaves the count at 0. It never wraps below zero.
- R10: A request is not issued in a cycle that carries an acknowledge, unmask or reload. The decision is taken again on the next cycle, using the updated state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timer expiry strobe |
| ack_i | input | 1 | One-cycle acknowledge of the outstanding request |
| unmask_i | input | 1 | One-cycle event: the interrupt line became unmasked |
| reload_i | input | 1 | One-cycle event: the timer was reprogrammed |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| pend_o | output | CNT_W (8) | Pending tick count |

## Verification
The hardest condition to reach is saturation of the pending count. It requires 255 ticks to pile up while only a single request goes out. The bench reaches it with a run of 260 back-to-back ticks and no acknowledges in between. It counts the request pulses seen during that run and expects exactly one. It then follows with a reload, and checks that the reload both clears the count and makes the next tick deliver at once. A second hard case is an acknowledge that coincides with a cycle in which a request would otherwise be issued. The bench creates it by putting a tick and an acknowledge on the same cycle right after the count first becomes nonzero.

// File: rtl/timpace_pkg.sv
package timpace_pkg;

   // Update applied to the pending counter in one cycle
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_INC  = 2'd1,
      CNT_DEC  = 2'd2,
      CNT_CLR  = 2'd3
   } cnt_op_e;

   // Priority decode of the per-cycle events
   function automatic cnt_op_e decode_op(input logic tick,
                                         input logic ack,
                                         input logic clr);
      cnt_op_e op;
      if (clr)
         op = CNT_CLR;
      else if (tick && ack)
         op = CNT_HOLD;
      else if (tick)
         op = CNT_INC;
      else if (ack)
         op = CNT_DEC;
      else
         op = CNT_HOLD;
      return op;
   endfunction

endpackage

// File: rtl/timpace_count.sv
module timpace_count
   import timpace_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ack,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   cnt_op_e          op;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_dec;

   assign op = decode_op(tick, ack, clr);

   // Increment variant chosen by parameter
   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + CNT_ONE;
      end
   endgenerate

   // Decrement stops at zero
   assign cnt_dec = (cnt_q == CNT_ZERO) ? cnt_q : cnt_q - CNT_ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_ZERO;
      end else begin
         unique case (op)
            CNT_INC:  cnt_q <= cnt_inc;
            CNT_DEC:  cnt_q <= cnt_dec;
            CNT_CLR:  cnt_q <= CNT_ZERO;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt = cnt_q;

   // R2: the count grows by one on a lone tick below the top value
   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ack && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

   generate
      if (SATURATE) begin : g_sat_chk
         // R2: the top value holds under further ticks
         assert_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !ack && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
      end
   endgenerate

   // R5: a lone acknowledge removes one pending tick
   assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !tick && !clr && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

   // R9: no wrap below zero
   assert_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !tick && cnt_q == CNT_ZERO) |=> (cnt_q == CNT_ZERO));

   // R6: tick and acknowledge together cancel
   assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && tick && !clr) |=> $stable(cnt_q));

   // R7, R8: clear events empty the counter
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == CNT_ZERO));

endmodule

// File: rtl/timpace_gate.sv
module timpace_gate #(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  logic             clr,
   input  logic [CNT_W-1:0] cnt,
   output logic             irq
);

   logic ready_q;
   logic fire;

   // Issue decision on registered state; any event this cycle defers it
   assign fire = ready_q && (|cnt) && !ack && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ready_q <= 1'b1;
      else if (clr || ack)
         ready_q <= 1'b1;
      else if (fire)
         ready_q <= 1'b0;
   end

   generate
      if (OUT_REG) begin : g_oreg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= fire;
         end
         assign irq = irq_q;

         // R4: the request never lasts two cycles
         assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq |=> !irq);

         // R3: a request follows only a nonzero count with the flag set
         assert_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ($past(ready_q) && $past(cnt) != '0));

         // R3: while the flag is clear and nothing sets it, no request
         assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ready_q && !ack && !clr) |=> !irq);

         // R10: an acknowledge or clear event blocks issue that cycle
         assert_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ack || clr) |=> !irq);
      end else begin : g_ocomb
         assign irq = fire;

         assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq |=> !irq);
      end
   endgenerate

   // R5, R7: acknowledge or clear events leave the flag set
   assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack || clr) |=> ready_q);

endmodule

// File: rtl/timpace_ctrl.sv
module timpace_ctrl #(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ack_i,
   input  logic             unmask_i,
   input  logic             reload_i,
   output logic             irq_o,
   output logic [CNT_W-1:0] pend_o
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $fatal(1, "timpace_ctrl: CNT_W must lie in 1..32");
      end
   endgenerate

   logic             restart;
   logic [CNT_W-1:0] pend;

   // Both restart events share one clear path
   assign restart = unmask_i || reload_i;

   timpace_count #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_i),
      .ack   (ack_i),
      .clr   (restart),
      .cnt   (pend)
   );

   timpace_gate #(
      .CNT_W   (CNT_W),
      .OUT_REG (OUT_REG)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .ack   (ack_i),
      .clr   (restart),
      .cnt   (pend),
      .irq   (irq_o)
   );

   assign pend_o = pend;

   // R1: state out of reset
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (pend_o == '0 && !irq_o));

   // R8: reload empties the count
   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (pend_o == '0));

endmodule

// File: tb/sim_timpace_ctrl.sv
`timescale 1ns/1ps
module sim_timpace_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       ack_i = 1'b0;
   logic       unmask_i = 1'b0;
   logic       reload_i = 1'b0;
   logic       irq_o;
   logic [7:0] pend_o;

   int total = 0;
   int bad = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   timpace_ctrl u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .ack_i    (ack_i),
      .unmask_i (unmask_i),
      .reload_i (reload_i),
      .irq_o    (irq_o),
      .pend_o   (pend_o)
   );

   // Drive events for one cycle; on return, outputs show the state after that edge
   task automatic step(input bit t, input bit a, input bit u, input bit r);
      tick_i = t; ack_i = a; unmask_i = u; reload_i = r;
      @(negedge clk);
      tick_i = 1'b0; ack_i = 1'b0; unmask_i = 1'b0; reload_i = 1'b0;
      if (irq_o) irq_seen++;
   endtask

   task automatic chk_pend(input string req, input int exp);
      total++;
      if (pend_o !== 8'(exp)) begin
         bad++;
         $display("FAIL %s pend_o actual=%0d expected=%0d", req, pend_o, exp);
      end
   endtask

   task automatic chk_irq(input string req, input bit exp);
      total++;
      if (irq_o !== exp) begin
         bad++;
         $display("FAIL %s irq_o actual=%0b expected=%0b", req, irq_o, exp);
      end
   endtask

   task automatic chk_cnt(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s pulses actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_pend("R1", 0);
      chk_irq("R1", 1'b0);
   endtask

   task automatic t_single();
      step(1, 0, 0, 0);
      chk_pend("R2", 1);
      chk_irq("R4", 1'b0);
      step(0, 0, 0, 0);
      chk_irq("R1", 1'b1);           // flag set from reset: delivered at once
      step(0, 0, 0, 0);
      chk_irq("R4", 1'b0);
      irq_seen = 0;
      repeat (4) step(0, 0, 0, 0);
      chk_cnt("R3", irq_seen, 0);
      step(0, 1, 0, 0);
      chk_pend("R5", 0);
      step(0, 0, 0, 0);
      chk_irq("R3", 1'b0);
   endtask

   task automatic t_accum();
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      chk_irq("R3", 1'b1);
      chk_pend("R2", 2);
      step(1, 0, 0, 0);
      chk_pend("R2", 3);
      chk_irq("R4", 1'b0);
      step(0, 1, 0, 0);
      chk_pend("R5", 2);
      chk_irq("R10", 1'b0);
      step(0, 0, 0, 0);
      chk_irq("R5", 1'b1);
      step(0, 1, 0, 0);
      chk_pend("R5", 1);
      step(0, 0, 0, 0);
      chk_irq("R5", 1'b1);
      step(0, 1, 0, 0);
      chk_pend("R5", 0);
      irq_seen = 0;
      repeat (3) step(0, 0, 0, 0);
      chk_cnt("R3", irq_seen, 0);
   endtask

   task automatic t_same();
      step(1, 0, 0, 0);
      step(1, 1, 0, 0);              // would fire now, acknowledge defers it
      chk_pend("R6", 1);
      chk_irq("R10", 1'b0);
      step(0, 0, 0, 0);
      chk_irq("R10", 1'b1);
      step(1, 1, 0, 0);              // flag clear before, set by this pair
      chk_pend("R6", 1);
      step(0, 0, 0, 0);
      chk_irq("R6", 1'b1);
      step(0, 1, 0, 0);
      chk_pend("R5", 0);
   endtask

   task automatic t_floor();
      step(0, 1, 0, 0);
      chk_pend("R9", 0);
      step(0, 1, 0, 0);
      chk_pend("R9", 0);
      chk_irq("R9", 1'b0);
   endtask

   task automatic t_sat();
      step(0, 0, 0, 1);
      irq_seen = 0;
      for (int i = 0; i < 260; i++) step(1, 0, 0, 0);
      chk_pend("R2", 255);
      chk_cnt("R3", irq_seen, 1);
      step(0, 0, 0, 1);
      chk_pend("R8", 0);
      step(1, 0, 0, 0);
      chk_pend("R8", 1);
      step(0, 0, 0, 0);
      chk_irq("R8", 1'b1);
   endtask

   task automatic t_unmask();
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      chk_pend("R2", 3);
      step(1, 1, 1, 0);              // unmask overrides tick and acknowledge
      chk_pend("R7", 0);
      chk_irq("R7", 1'b0);
      step(1, 0, 0, 0);
      chk_pend("R7", 1);
      step(0, 0, 0, 0);
      chk_irq("R7", 1'b1);
      step(0, 0, 0, 1);
      chk_pend("R8", 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_single();
      t_accum();
      t_same();
      t_floor();
      t_sat();
      t_unmask();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule